// File: doc/BRIEF.md
# Clocked External Bus Slave Bridge

This block sits on the FPGA side of a clocked, active-low memory-style bus that a host processor masters. The host moves its controls and data while the clock is low, and the slave samples all of them on the rising edge. The slave turns host write cycles into write-port pulses and host read cycles into read-port requests. A run of clocks with the write control held low is treated as a burst. Each clock of that run becomes a beat of its own, and each beat has its own index and address.

Every bus input first passes through one register stage. Decode works only on those registered copies. Each beat produces a one-cycle write strobe, together with the data word, the beat index and a write address equal to a fixed base plus the beat index. A read cycle raises a one-cycle read request. The word returned by the internal read port is captured once and then held on the outbound data lines for the whole read window. The data-drive enable for the pin buffer comes from a register. The data inputs, data outputs and drive enable are separate ports, and the tri-state pad is wired around them.

Top module: `ebus_slave_bridge`

## Requirements
- R1: In reset and directly after it, `wr_stb`, `rd_req` and `bus_dout_en` are 0.
- R2: Suppose `bus_cs_n`=0, `bus_we_n`=0 and `bus_oe_n`=1 are sampled at rising edge k. Then during the cycle after edge k+1, `wr_stb` is 1 for exactly one cycle, `wr_data` equals the sampled `bus_din`, `wr_beat` is 0 and `wr_addr` equals BASE.
- R3: N consecutive sampled write cycles produce N consecutive strobe cycles in the same order. The beats run 0..N-1, the address of each is BASE plus its beat, and the data appears in the order presented.
- R4: The beat index returns to 0 after any sampled cycle with `bus_cs_n`=1. While `bus_cs_n` stays 0 and no write is sampled, the index holds.
- R5: Suppose `bus_cs_n`=0, `bus_oe_n`=0 and `bus_we_n`=1 are first sampled at edge k. Then `rd_req` is 1 for exactly the cycle after edge k, and `bus_dout` takes `rd_data` at edge k+1.
- R6: For a two-cycle host read sampled at edges k and k+1, `bus_dout_en` is 1 after edges k+1 and k+2 and returns to 0 after edge k+3.
- R7: While `bus_dout_en` stays 1, `bus_dout` does not change, even if `rd_data` changes.
- R8: A sampled cycle with `bus_cs_n`, `bus_we_n` and `bus_oe_n` all 0 produces no write strobe, no read request and no drive enable.
- R9: When `bus_cs_n`=1 is sampled, the levels of `bus_we_n` and `bus_oe_n` produce no strobe, no request and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_din | input | DW | Data from the pins |
| bus_dout | output | DW | Data toward the pins |
| bus_dout_en | output | 1 | Registered drive enable for the pin buffer |
| wr_stb | output | 1 | One-cycle pulse per write beat |
| wr_addr | output | AW | BASE plus beat index |
| wr_beat | output | BEAT_W | Beat index within the burst |
| wr_data | output | DW | Captured write word |
| rd_req | output | 1 | One-cycle read request |
| rd_data | input | DW | Word from the internal read port |

## Verification
Single writes, four-beat bursts and bursts split by a chip-select gap or by an idle cycle with chip select still low separate three cases: one strobe, consecutive beats, and index reset against index hold. Single reads show request timing, the exact window of the drive enable, and that the output word stays put while the read port changes underneath it. Cycles with both write and output enable low, and cycles with write or output enable low while chip select is high, show that decode requires chip select together with exactly one of the two enables.

// File: rtl/ebus_slave_bridge.sv
module ebus_slave_bridge #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int BEAT_W = 3,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [DW-1:0]     bus_din,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_dout_en,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [BEAT_W-1:0] wr_beat,
  output logic [DW-1:0]     wr_data,
  output logic              rd_req,
  input  logic [DW-1:0]     rd_data
);

  logic          cs_q, we_q, oe_q;
  logic [DW-1:0] din_q;
  logic          rd_prev;
  logic [BEAT_W-1:0] beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
      din_q <= '0;
    end else begin
      cs_q  <= bus_cs_n;
      we_q  <= bus_we_n;
      oe_q  <= bus_oe_n;
      din_q <= bus_din;
    end
  end

  wire wr_cyc = ~cs_q & ~we_q & oe_q;
  wire rd_cyc = ~cs_q & ~oe_q & we_q;

  assign rd_req = rd_cyc & ~rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev     <= 1'b0;
      bus_dout_en <= 1'b0;
      bus_dout    <= '0;
    end else begin
      rd_prev     <= rd_cyc;
      bus_dout_en <= rd_cyc;
      if (rd_req) bus_dout <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      wr_beat  <= '0;
      wr_addr  <= '0;
    end else begin
      wr_stb <= wr_cyc;
      if (cs_q) beat_cnt <= '0;
      else if (wr_cyc) beat_cnt <= beat_cnt + 1'b1;
      if (wr_cyc) begin
        wr_data <= din_q;
        wr_beat <= beat_cnt;
        wr_addr <= BASE + AW'(beat_cnt);
      end
    end
  end

endmodule

// File: rtl/ebus_slave_chk.sv
module ebus_slave_chk #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs_n,
  input logic              bus_we_n,
  input logic              bus_oe_n,
  input logic [DW-1:0]     bus_dout,
  input logic              bus_dout_en,
  input logic              wr_stb,
  input logic [BEAT_W-1:0] wr_beat,
  input logic              rd_req
);

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  // R5
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dout_en && $past(bus_dout_en)) |-> $stable(bus_dout));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && wr_stb && $past(wr_stb)) |-> (wr_beat == $past(wr_beat) + 1'b1));

  // R4
  beat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && wr_stb && $past(bus_cs_n, 3)) |-> (wr_beat == '0));

  // R8
  conflict_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && !$past(bus_cs_n, 2) && !$past(bus_we_n, 2) && !$past(bus_oe_n, 2)) |-> !wr_stb);

  // R8
  conflict_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd2 && !$past(bus_cs_n) && !$past(bus_we_n) && !$past(bus_oe_n)) |-> !rd_req);

  // R9
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && $past(bus_cs_n, 2)) |-> !wr_stb);

  // R6
  drive_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dout_en) |-> $past(rd_req));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!wr_stb && !bus_dout_en);
    end
  end

endmodule

bind ebus_slave_bridge ebus_slave_chk #(.DW(DW), .AW(AW), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
  .bus_oe_n(bus_oe_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
  .wr_stb(wr_stb), .wr_beat(wr_beat), .rd_req(rd_req)
);

// File: tb/sim_ebus_slave_bridge.sv
module sim_ebus_slave_bridge;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int BEAT_W = 3;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rd_val = '0;
  logic [DW-1:0] dout;
  logic dout_en, wr_stb, rd_req;
  logic [AW-1:0] wr_addr;
  logic [BEAT_W-1:0] wr_beat;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nlog = 0, nreq = 0;
  logic [DW-1:0] log_d [16];
  logic [BEAT_W-1:0] log_b [16];
  logic [AW-1:0] log_a [16];
  int log_c [16];

  always #2 clk = ~clk;

  ebus_slave_bridge #(.DW(DW), .AW(AW), .BEAT_W(BEAT_W), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_beat(wr_beat), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_val)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wr_stb && nlog < 16) begin
      log_d[nlog] = wr_data;
      log_b[nlog] = wr_beat;
      log_a[nlog] = wr_addr;
      log_c[nlog] = cyc;
      nlog = nlog + 1;
    end
    if (rst_n && rd_req) nreq = nreq + 1;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk(!wr_stb && !rd_req && !dout_en, "R1 during reset", {wr_stb, rd_req, dout_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_stb && !rd_req && !dout_en, "R1 after reset", {wr_stb, rd_req, dout_en}, 0);
  endtask

  task automatic t_single_write(input logic [DW-1:0] d);
    @(negedge clk); cs_n = 0; we_n = 0; din = d;
    @(negedge clk); cs_n = 1; we_n = 1; din = '1;
    chk(!wr_stb, "R2 no strobe yet", wr_stb, 0);
    @(negedge clk);
    chk(wr_stb, "R2 strobe", wr_stb, 1);
    chk(wr_data == d, "R2 data", wr_data, d);
    chk(wr_beat == 0 && wr_addr == BASE, "R2 beat/addr", wr_addr, BASE);
    @(negedge clk);
    chk(!wr_stb, "R2 single pulse", wr_stb, 0);
  endtask

  task automatic t_burst(input int n, input logic [DW-1:0] seed);
    nlog = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 0; we_n = 0; din = seed + DW'(i);
    end
    idle(4);
    chk(nlog == n, "R3 beat count", nlog, n);
    for (int i = 0; i < n; i++) begin
      chk(log_d[i] == seed + DW'(i), "R3 data order", log_d[i], seed + DW'(i));
      chk(log_b[i] == BEAT_W'(i), "R3 beat index", log_b[i], i);
      chk(log_a[i] == BASE + AW'(i), "R3 address", log_a[i], BASE + AW'(i));
      if (i > 0) chk(log_c[i] == log_c[i-1] + 1, "R3 consecutive", log_c[i] - log_c[i-1], 1);
    end
  endtask

  task automatic t_gap_restart;
    nlog = 0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); cs_n = 0; we_n = 0; din = 16'hA0 + DW'(i); end
    @(negedge clk); cs_n = 1; we_n = 1;
    for (int i = 0; i < 2; i++) begin @(negedge clk); cs_n = 0; we_n = 0; din = 16'hB0 + DW'(i); end
    idle(4);
    chk(nlog == 4, "R4 gap count", nlog, 4);
    chk(log_b[2] == 0 && log_b[3] == 1, "R4 restart after cs high", {log_b[2], log_b[3]}, 1);
  endtask

  task automatic t_hold_index;
    nlog = 0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); cs_n = 0; we_n = 0; din = 16'hC0 + DW'(i); end
    @(negedge clk); cs_n = 0; we_n = 1;
    @(negedge clk); cs_n = 0; we_n = 0; din = 16'hC2;
    idle(4);
    chk(nlog == 3, "R4 hold count", nlog, 3);
    chk(log_b[2] == 2 && log_a[2] == BASE + 2, "R4 index held", log_b[2], 2);
  endtask

  task automatic t_read(input logic [DW-1:0] v, input logic [DW-1:0] v2);
    rd_val = v; nreq = 0;
    @(negedge clk); cs_n = 0; oe_n = 0;
    @(negedge clk);
    chk(rd_req && !dout_en, "R5 request pulse", {rd_req, dout_en}, 2);
    @(negedge clk); cs_n = 1; oe_n = 1;
    chk(!rd_req, "R5 request one cycle", rd_req, 0);
    chk(dout_en, "R6 drive on", dout_en, 1);
    chk(dout == v, "R5 read word", dout, v);
    rd_val = v2;
    @(negedge clk);
    chk(dout_en, "R6 drive second cycle", dout_en, 1);
    chk(dout == v, "R7 word held", dout, v);
    @(negedge clk);
    chk(!dout_en, "R6 release", dout_en, 0);
    chk(nreq == 1, "R5 request count", nreq, 1);
  endtask

  task automatic t_conflict;
    nlog = 0; nreq = 0;
    @(negedge clk); cs_n = 0; we_n = 0; oe_n = 0; din = 16'hDEAD;
    @(negedge clk); cs_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk);
    chk(!dout_en, "R8 no drive", dout_en, 0);
    idle(3);
    chk(nlog == 0 && nreq == 0, "R8 no strobe/request", nlog + nreq, 0);
  endtask

  task automatic t_deselect;
    nlog = 0; nreq = 0;
    @(negedge clk); cs_n = 1; we_n = 0; oe_n = 1; din = 16'hBEEF;
    @(negedge clk); cs_n = 1; we_n = 1; oe_n = 0;
    @(negedge clk); oe_n = 1;
    chk(!dout_en, "R9 no drive", dout_en, 0);
    idle(3);
    chk(nlog == 0 && nreq == 0, "R9 ignored when deselected", nlog + nreq, 0);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset();
        t_single_write(16'h1234);
        idle(2);
        t_burst(4, 16'h5500);
        t_gap_restart();
        t_hold_index();
        t_read(16'h7E57, 16'h0BAD);
        idle(2);
        t_read(16'hCAFE, 16'h1111);
        t_conflict();
        t_deselect();
        t_single_write(16'hFFFF);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule